// File: doc/BRIEF.md
# Pattern Resynchronizer with Pause Insertion

This block sits between a pattern generator and the front-end electronics it drives. The generator offers 16-track pattern words at up to 20 MHz through a two-wire toggle handshake. The block moves each word onto its own local clock through a two-stage synchronizer and replays it at a slower, programmable rate. Every accepted word stays on the outputs for a number of local cycles set by a divider register. When a chosen track of the word is high, the word stays on the outputs for a further programmable pause, which lengthens the integration time of the connected sensor.

Each output pin is fed from a per-output selector. The selector can take a pattern track, the inverse of a pattern track, a bit of a static control register set over the register write port, or a constant low. Lines that stay constant during operation therefore do not use up pattern tracks. If the generator has no word ready when the next word is due, the last word stays on the outputs and an underrun flag is raised until a new word is accepted.

Top module: `pattern_resync`

## Requirements
- R1: While reset is applied and afterwards until the first word is accepted, `pattOut`, `srcAck` and `underrun` are 0. After reset every output j is routed straight to pattern track j, the divider is 1, the pause length is 0 and the pause track is 15.
- R2: A word is pending whenever `srcTgl` differs from `srcAck`. On acceptance the block copies `srcData` and sets `srcAck` equal to the synchronized `srcTgl`. `srcAck` changes at no other time. When the block is idle, a toggle made between two rising edges shows the new word on `pattOut` after the fourth following rising edge.
- R3: Each accepted word stays on the outputs for exactly N local cycles, where N is register address 0 (0 acts as 1). This holds when the word's pause track is low or the pause length is 0.
- R4: If the word's bit on the pause track is high, the word stays for N + P cycles, where P is register address 1.
- R5: Only the track selected by register address 2 (bits 3:0) starts a pause. High bits on any other track do not change the hold length.
- R6: If no word is pending when the hold expires after the first acceptance, the last word stays on the outputs and `underrun` rises in that same cycle. `underrun` returns to 0 on the next acceptance.
- R7: Register address 4+j selects the source of output j. Bits 5:4 select the kind and bits 3:0 the index: 0 = pattern track, 1 = static register bit, 2 = inverted pattern track, 3 = constant 0.
- R8: Register address 3 holds the static bits. A write reaches the routed outputs one cycle after the write edge, whatever the pattern timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTgl | input | 1 | Source toggles this to offer a new word |
| srcData | input | 16 | Offered pattern word, stable while pending |
| srcAck | output | 1 | Copy of the last accepted toggle value |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 16 | Register write data |
| pattOut | output | 16 | Routed output lines, registered |
| underrun | output | 1 | Last word held past its due time |

## Verification
A toggle made at a falling edge reaches the synchronizer's second stage after two rising edges. It is accepted at the third and appears on `pattOut` after the fourth. The bench counts falling edges from the toggle and expects the first word at the fourth. Hold lengths are measured as the number of falling-edge samples between changes of `pattOut`, and each is compared with N or N + P computed from that word's bits. `underrun` has no output register, so it is expected on the sample where the held word reaches its full length and not one sample earlier. A static write shows on the outputs at the second falling edge after the write is driven, and the bench samples both of those edges.

// File: rtl/presync_pkg.sv
package presync_pkg;

  typedef enum logic [1:0] {
    SEL_TRACK  = 2'd0,
    SEL_STATIC = 2'd1,
    SEL_INVERT = 2'd2,
    SEL_ZERO   = 2'd3
  } selKind_e;

  typedef struct packed {
    logic load;
  } ctlStrobe_t;

  localparam int REG_DIV       = 0;
  localparam int REG_PAUSE_LEN = 1;
  localparam int REG_PAUSE_IDX = 2;
  localparam int REG_STATIC    = 3;
  localparam int REG_SEL_BASE  = 4;

endpackage

// File: rtl/presync_cfg.sv
module presync_cfg
  import presync_pkg::*;
#(
  parameter int TRACKS = 16,
  parameter int NOUT   = 16,
  parameter int NSTAT  = 16,
  parameter int REGW   = 16,
  parameter int IDXW   = 4,
  parameter int SELW   = 6,
  parameter int ADDRW  = 5,
  localparam int TIDXW = $clog2(TRACKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDRW-1:0]  regAddr,
  input  logic [REGW-1:0]   regWdata,
  output logic [REGW-1:0]   divQ,
  output logic [REGW-1:0]   pauseLenQ,
  output logic [TIDXW-1:0]  pauseIdxQ,
  output logic [NSTAT-1:0]  staticQ,
  output logic [SELW-1:0]   selQ [NOUT]
);

  localparam logic [ADDRW-1:0] A_DIV   = ADDRW'(REG_DIV);
  localparam logic [ADDRW-1:0] A_PLEN  = ADDRW'(REG_PAUSE_LEN);
  localparam logic [ADDRW-1:0] A_PIDX  = ADDRW'(REG_PAUSE_IDX);
  localparam logic [ADDRW-1:0] A_STAT  = ADDRW'(REG_STATIC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ      <= REGW'(1);
      pauseLenQ <= '0;
      pauseIdxQ <= TIDXW'(TRACKS - 1);
      staticQ   <= '0;
    end else if (regWe) begin
      if (regAddr == A_DIV)  divQ      <= regWdata;
      if (regAddr == A_PLEN) pauseLenQ <= regWdata;
      if (regAddr == A_PIDX) pauseIdxQ <= regWdata[TIDXW-1:0];
      if (regAddr == A_STAT) staticQ   <= regWdata[NSTAT-1:0];
    end
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_sel
    localparam logic [ADDRW-1:0] A_SEL = ADDRW'(REG_SEL_BASE + j);
    localparam logic [SELW-1:0]  SEL_RST = SELW'({SEL_TRACK, IDXW'(j % TRACKS)});
    always_ff @(posedge clk) begin
      if (!rstN)                           selQ[j] <= SEL_RST;
      else if (regWe && regAddr == A_SEL)  selQ[j] <= regWdata[SELW-1:0];
    end
  end

endmodule

// File: rtl/presync_ctl.sv
module presync_ctl
  import presync_pkg::*;
#(
  parameter int REGW = 16,
  localparam int CW  = REGW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pending,
  input  logic            pauseHit,
  input  logic [REGW-1:0] divQ,
  input  logic [REGW-1:0] pauseLenQ,
  output ctlStrobe_t      strobe,
  output logic            underrun
);

  logic [CW-1:0]   holdCnt;
  logic [CW-1:0]   holdTotal;
  logic [REGW-1:0] divEff;
  logic            waiting;
  logic            started;
  logic            due;

  always_comb begin
    divEff    = (divQ == '0) ? REGW'(1) : divQ;
    holdTotal = {1'b0, divEff} + (pauseHit ? {1'b0, pauseLenQ} : CW'(0));
    due       = waiting || (holdCnt == '0);
    strobe    = '0;
    strobe.load = due && pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt  <= '0;
      waiting  <= 1'b1;
      started  <= 1'b0;
      underrun <= 1'b0;
    end else if (strobe.load) begin
      holdCnt  <= holdTotal - CW'(1);
      waiting  <= 1'b0;
      started  <= 1'b1;
      underrun <= 1'b0;
    end else if (due) begin
      waiting  <= 1'b1;
      underrun <= started;
    end else begin
      holdCnt  <= holdCnt - CW'(1);
    end
  end

endmodule

// File: rtl/presync_dp.sv
module presync_dp
  import presync_pkg::*;
#(
  parameter int TRACKS = 16,
  parameter int NOUT   = 16,
  parameter int NSTAT  = 16,
  parameter int IDXW   = 4,
  parameter int SELW   = 6,
  localparam int TIDXW = $clog2(TRACKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcTgl,
  input  logic [TRACKS-1:0] srcData,
  input  ctlStrobe_t        strobe,
  input  logic [TIDXW-1:0]  pauseIdxQ,
  input  logic [NSTAT-1:0]  staticQ,
  input  logic [SELW-1:0]   selQ [NOUT],
  output logic              pending,
  output logic              pauseHit,
  output logic              srcAck,
  output logic [TRACKS-1:0] wordQ,
  output logic [NOUT-1:0]   pattOut
);

  logic            tglMeta;
  logic            tglSync;
  logic            ackQ;
  logic [NOUT-1:0] muxNext;

  function automatic logic pickBit(input logic [SELW-1:0] sel,
                                   input logic [TRACKS-1:0] word,
                                   input logic [NSTAT-1:0] stat);
    logic [IDXW-1:0] idx;
    logic r;
    idx = sel[IDXW-1:0];
    r = 1'b0;
    case (selKind_e'(sel[SELW-1 -: 2]))
      SEL_TRACK:  if (int'(idx) < TRACKS) r = word[idx];
      SEL_STATIC: if (int'(idx) < NSTAT)  r = stat[idx];
      SEL_INVERT: if (int'(idx) < TRACKS) r = ~word[idx];
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  assign pending  = tglSync ^ ackQ;
  assign pauseHit = srcData[pauseIdxQ];
  assign srcAck   = ackQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tglMeta <= 1'b0;
      tglSync <= 1'b0;
      ackQ    <= 1'b0;
      wordQ   <= '0;
    end else begin
      tglMeta <= srcTgl;
      tglSync <= tglMeta;
      if (strobe.load) begin
        ackQ  <= tglSync;
        wordQ <= srcData;
      end
    end
  end

  for (genvar j = 0; j < NOUT; j++) begin : g_mux
    assign muxNext[j] = pickBit(selQ[j], wordQ, staticQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pattOut <= '0;
    else       pattOut <= muxNext;
  end

endmodule

// File: rtl/pattern_resync.sv
module pattern_resync
  import presync_pkg::*;
#(
  parameter int TRACKS = 16,
  parameter int NOUT   = 16,
  parameter int NSTAT  = 16,
  parameter int REGW   = 16,
  localparam int IDXW  = $clog2((TRACKS > NSTAT) ? TRACKS : NSTAT),
  localparam int SELW  = IDXW + 2,
  localparam int ADDRW = $clog2(REG_SEL_BASE + NOUT),
  localparam int TIDXW = $clog2(TRACKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcTgl,
  input  logic [TRACKS-1:0] srcData,
  output logic              srcAck,
  input  logic              regWe,
  input  logic [ADDRW-1:0]  regAddr,
  input  logic [REGW-1:0]   regWdata,
  output logic [NOUT-1:0]   pattOut,
  output logic              underrun
);

  ctlStrobe_t        ctlStrobe;
  logic              wordPending;
  logic              pauseHit;
  logic [TRACKS-1:0] heldWord;
  logic [REGW-1:0]   divQ;
  logic [REGW-1:0]   pauseLenQ;
  logic [TIDXW-1:0]  pauseIdxQ;
  logic [NSTAT-1:0]  staticQ;
  logic [SELW-1:0]   selQ [NOUT];

  presync_cfg #(
    .TRACKS(TRACKS), .NOUT(NOUT), .NSTAT(NSTAT), .REGW(REGW),
    .IDXW(IDXW), .SELW(SELW), .ADDRW(ADDRW)
  ) u_cfg (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .divQ(divQ), .pauseLenQ(pauseLenQ), .pauseIdxQ(pauseIdxQ),
    .staticQ(staticQ), .selQ(selQ)
  );

  presync_ctl #(.REGW(REGW)) u_ctl (
    .clk(clk), .rstN(rstN), .pending(wordPending), .pauseHit(pauseHit),
    .divQ(divQ), .pauseLenQ(pauseLenQ), .strobe(ctlStrobe), .underrun(underrun)
  );

  presync_dp #(
    .TRACKS(TRACKS), .NOUT(NOUT), .NSTAT(NSTAT), .IDXW(IDXW), .SELW(SELW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcTgl(srcTgl), .srcData(srcData), .strobe(ctlStrobe),
    .pauseIdxQ(pauseIdxQ), .staticQ(staticQ), .selQ(selQ),
    .pending(wordPending), .pauseHit(pauseHit), .srcAck(srcAck),
    .wordQ(heldWord), .pattOut(pattOut)
  );

endmodule

// File: rtl/presync_chk.sv
module presync_chk
  import presync_pkg::*;
#(
  parameter int TRACKS = 16
) (
  input logic              clk,
  input logic              rstN,
  input ctlStrobe_t        strobe,
  input logic              pending,
  input logic              underrun,
  input logic              srcAck,
  input logic [TRACKS-1:0] heldWord
);

  // R2: acceptance only while a toggle is outstanding
  a_r2_load_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> pending);

  // R2: acknowledge moves only on acceptance
  a_r2_ack_only_on_load: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(srcAck));

  // R6: during underrun the held word is frozen
  a_r6_stall_keeps_word: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !strobe.load) |=> $stable(heldWord));

  // R6: acceptance clears underrun
  a_r6_clear_on_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !underrun);

  // R6: underrun never rises on an acceptance edge
  a_r6_rise_without_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !$rose(underrun));

endmodule

bind pattern_resync presync_chk #(.TRACKS(TRACKS)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(ctlStrobe), .pending(wordPending),
  .underrun(underrun), .srcAck(srcAck), .heldWord(heldWord)
);

// File: tb/sim_pattern_resync.sv
module sim_pattern_resync;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcTgl = 1'b0;
  logic [15:0] srcData = '0;
  logic        srcAck;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] pattOut;
  logic        underrun;

  int checks = 0;
  int fails = 0;
  logic [5:0]  selM [16];
  logic [15:0] staticM = '0;
  logic [15:0] lastW = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_resync u0 (
    .clk(clk), .rstN(rstN), .srcTgl(srcTgl), .srcData(srcData), .srcAck(srcAck),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .pattOut(pattOut), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 5'(addr); regWdata = 16'(data);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic sendWord(input logic [15:0] w);
    srcData = w;
    srcTgl  = ~srcTgl;
    do @(negedge clk); while (srcAck != srcTgl);
  endtask

  function automatic logic [15:0] modelOut(input logic [15:0] w);
    logic [15:0] r;
    for (int j = 0; j < 16; j++) begin
      case (selM[j][5:4])
        2'd0: r[j] = w[selM[j][3:0]];
        2'd1: r[j] = staticM[selM[j][3:0]];
        2'd2: r[j] = ~w[selM[j][3:0]];
        default: r[j] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic runBurst(input int id, input int divN, input int plen, input int pidx,
                          input string durTag);
    logic [15:0] w [NW];
    int dur [NW];
    for (int i = 0; i < NW; i++) begin
      w[i] = 16'((i % 2) << 15) | 16'(((i % 3) == 0) << 14) | 16'(id << 8) | 16'(i + 1);
      dur[i] = divN + (w[i][pidx] ? plen : 0);
    end
    writeReg(0, divN);
    writeReg(1, plen);
    writeReg(2, pidx);
    fork
      begin
        for (int i = 0; i < NW; i++) sendWord(w[i]);
      end
      begin
        int idx = 0, cnt = 0, lat = 0, guard = 0;
        bit done = 0;
        logic [15:0] cur;
        cur = pattOut;
        while (!done && guard < 3000) begin
          @(negedge clk);
          guard++; lat++;
          if (pattOut !== cur) begin
            if (idx == 0) begin
              check(lat == 4, "R2 first-word latency", lat, 4);
              check(underrun == 1'b0, "R6 cleared on accept", underrun, 0);
            end else begin
              check(cnt == dur[idx-1], durTag, cnt, dur[idx-1]);
            end
            if (idx < NW) check(pattOut == w[idx], "R3 word value", pattOut, w[idx]);
            else          check(1'b0, "R6 unexpected change", pattOut, w[NW-1]);
            cur = pattOut; idx++; cnt = 1;
          end else begin
            cnt++;
          end
          if (idx == NW) begin
            if (cnt == dur[NW-1] - 1) check(underrun == 1'b0, "R6 not early", underrun, 0);
            if (cnt == dur[NW-1]) begin
              check(underrun == 1'b1, "R6 underrun raised", underrun, 1);
              check(pattOut == w[NW-1], "R6 last word held", pattOut, w[NW-1]);
            end
            if (cnt == dur[NW-1] + 3) done = 1;
          end
        end
        check(done, "R3 burst completed", idx, NW);
      end
    join
    lastW = w[NW-1];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int divs [3];
    int plens [3];
    int id;
    logic [15:0] wm;
    divs = '{3, 4, 6};
    plens = '{0, 2, 5};
    for (int j = 0; j < 16; j++) selM[j] = 6'(j);
    repeat (3) @(negedge clk);
    check(pattOut == 16'h0 && srcAck == 1'b0 && underrun == 1'b0, "R1 in reset",
          {pattOut, 7'b0, srcAck, 7'b0, underrun}, 0);
    rstN = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(underrun == 1'b0 && pattOut == 16'h0 && srcAck == 1'b0, "R1 idle before first word",
            {pattOut, 7'b0, srcAck, 7'b0, underrun}, 0);
    end

    id = 1;
    for (int d = 0; d < 3; d++) begin
      for (int p = 0; p < 3; p++) begin
        runBurst(id, divs[d], plens[p], 15, (plens[p] == 0) ? "R3 hold length" : "R4 pause length");
        id++;
      end
    end
    // R5: pause track moved to 14, bit 15 must no longer pause
    runBurst(id, 4, 5, 14, "R5 designated track only");
    id++;

    // R7: routing kinds
    writeReg(4, 6'h12);  selM[0] = 6'h12;
    writeReg(5, 6'h25);  selM[1] = 6'h25;
    writeReg(6, 6'h30);  selM[2] = 6'h30;
    writeReg(7, 6'h0F);  selM[3] = 6'h0F;
    writeReg(3, 16'h0004); staticM = 16'h0004;
    @(negedge clk);
    check(pattOut == modelOut(lastW), "R7 routing on held word", pattOut, modelOut(lastW));

    // R8: static write timing
    writeReg(3, 16'h0000);
    check(pattOut[0] == 1'b1, "R8 old static before update", pattOut[0], 1);
    staticM = 16'h0000;
    @(negedge clk);
    check(pattOut[0] == 1'b0, "R8 static one cycle after write", pattOut[0], 0);
    check(pattOut == modelOut(lastW), "R8 full output after static write", pattOut, modelOut(lastW));
    writeReg(3, 16'h0004); staticM = 16'h0004;
    @(negedge clk);
    check(pattOut[0] == 1'b1, "R8 static set again", pattOut[0], 1);

    // R7: new word through the remapped outputs
    writeReg(0, 3);
    writeReg(1, 0);
    wm = 16'h8025;
    sendWord(wm);
    repeat (4) @(negedge clk);
    check(pattOut == modelOut(wm), "R7 routing on new word", pattOut, modelOut(wm));
    wm = 16'h0A50;
    sendWord(wm);
    repeat (4) @(negedge clk);
    check(pattOut == modelOut(wm), "R7 inverted and zero kinds", pattOut, modelOut(wm));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule